// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Command Engine

This block is the slave end of a two-wire serial memory with a 64K x 8 array. It oversamples the clock and data lines with the system clock and finds Start and Stop conditions. It shifts bytes in and out most significant bit first and drives the acknowledge bit by pulling the data line low through an open-drain output enable. It checks each control byte against its device code and chip-select pins. It collects a two-byte word address and runs byte writes, page writes, current-address reads, random reads and sequential reads.

The array itself and the page-write unit live outside the block. Reads go through a registered address output, and the array returns the byte one clock later. Writes go to the page-write unit as a load pulse for each received data byte. A commit pulse follows when the master sends Stop, and a cancel pulse follows when the master sends a repeated Start first. The page-write unit reports a busy level while its internal write cycle runs. While that level is high the block acknowledges nothing.

Top module: `serial_mem_slave`

## Requirements
- R1: The control byte holds the code 1010 in bits 7:4, the half-select bit in bit 3, the chip-select bits in bits 2:1 and the read/write flag in bit 0 (1 = read). It is acknowledged, by SDA held low on the ninth clock, only when the code matches and bits 2:1 equal `cs_pins`. Otherwise SDA stays released.
- R2: While `cs_en` is low, no control byte is acknowledged.
- R3: Start is SDA falling while SCL is high, and Stop is SDA rising while SCL is high. Data bits are sampled only on SCL rising. A Start in any state abandons the transfer in progress and begins reception of a new control byte.
- R4: After a write control byte, the next two bytes are the word address, high byte first. Bit 7 of the high byte is ignored, and the half-select bit of the control byte becomes address bit 15. Every later data byte produces one `pw_load` pulse that carries the byte and its target address.
- R5: During a write, the pointer advances only in its low 6 bits. Data beyond the end of a 64-byte page wraps to the start of the same page.
- R6: A Stop that ends a write with at least one data byte gives exactly one `pw_commit` pulse. A repeated Start in that position gives `pw_cancel` instead, and the staged data is never written. A Stop after an address-only write starts no write cycle.
- R7: While `wr_busy` is high, no byte of any kind is acknowledged.
- R8: A repeated Start after the address bytes keeps the loaded pointer. A following read control byte returns data from it, and its half-select bit replaces pointer bit 15.
- R9: A master ACK after a read byte makes the block send the next byte. A master NACK makes it release SDA and stay idle until the next Start or Stop.
- R10: During reads, the pointer wraps from 7FFFh to 0000h and from FFFFh to 8000h, and it never crosses between the two halves.
- R11: After any read or write, the pointer holds the address after the last byte accessed. A read control byte sent with no address uses that pointer.
- R12: The block changes its SDA drive only while SCL is low, and it keeps SDA released during the master's acknowledge slot.
- R13: After reset, SDA is released and no load, commit or cancel pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 = pull SDA low (open drain) |
| cs_pins | input | 2 | Chip-select strap levels compared with control bits 2:1 |
| cs_en | input | 1 | Fixed-high enable strap; low disables the device |
| wr_busy | input | 1 | Page-write unit is in its internal write cycle |
| rd_addr | output | AW | Array read address (registered) |
| rd_data | input | 8 | Array read data, valid one clock after rd_addr |
| pw_load | output | 1 | One-clock pulse per received data byte |
| pw_addr | output | AW | Target address for pw_load |
| pw_data | output | 8 | Data byte for pw_load |
| pw_commit | output | 1 | One-clock pulse: start the internal write cycle |
| pw_cancel | output | 1 | One-clock pulse: discard staged bytes |

## Verification
The bench builds the block with its default sizes: a 16-bit address, 64-byte pages and a two-stage synchronizer. With these sizes the read wraps at 7FFFh and FFFFh and the write wrap at a page boundary can be reached directly with short transfers. A bench model of the array and page-write unit holds the busy level for a fixed number of clocks after each commit. The first acknowledge poll after every write therefore falls inside the busy window, and later polls fall after it. Random transactions with random half bits and addresses, including addresses with bit 7 of the high byte set, run alongside directed tests of aborted transfers, cancelled writes and wrong device selections.

// File: rtl/sms_pkg.sv
package sms_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXEND,
    ST_ACK,
    ST_TX,
    ST_TXACK,
    ST_TXNEXT
  } sms_state_e;

  typedef enum logic [1:0] {
    PH_CTRL,
    PH_AHI,
    PH_ALO,
    PH_DATA
  } sms_phase_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/sms_line_sync.sv
module sms_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_now, sda_now;

  assign scl_now = scl_sh[STAGES-1];
  assign sda_now = sda_sh[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh   <= '1;
      sda_sh   <= '1;
      scl_lvl  <= 1'b1;
      sda_lvl  <= 1'b1;
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
      start_ev <= 1'b0;
      stop_ev  <= 1'b0;
    end else begin
      scl_sh   <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh   <= {sda_sh[STAGES-2:0], sda_i};
      scl_lvl  <= scl_now;
      sda_lvl  <= sda_now;
      scl_rise <= scl_now & ~scl_lvl;
      scl_fall <= ~scl_now & scl_lvl;
      start_ev <= scl_now & scl_lvl & sda_lvl & ~sda_now;
      stop_ev  <= scl_now & scl_lvl & ~sda_lvl & sda_now;
    end
  end

  // R3: a Start is only reported with the clock line high and data low
  p_start_level_r3: assert property (@(posedge clk) disable iff (rst)
    start_ev |-> (scl_lvl && !sda_lvl));
endmodule

// File: rtl/sms_addr_ptr.sv
module sms_addr_ptr #(
  parameter int AW = 16,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          set_top,
  input  logic          top_val,
  input  logic          inc_rd,
  input  logic          inc_wr,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-2:0] ONE_HALF = {{(AW-2){1'b0}}, 1'b1};
  localparam logic [PW-1:0] ONE_PAGE = {{(PW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= load_val;
    end else if (set_top) begin
      ptr[AW-1] <= top_val;
    end else if (inc_rd) begin
      ptr[AW-2:0] <= ptr[AW-2:0] + ONE_HALF;
    end else if (inc_wr) begin
      ptr[PW-1:0] <= ptr[PW-1:0] + ONE_PAGE;
    end
  end

  // R10: a read step never changes the half bit
  p_half_keep_r10: assert property (@(posedge clk) disable iff (rst)
    (inc_rd && !load && !set_top) |=> (ptr[AW-1] == $past(ptr[AW-1])));

  // R5: a write step never leaves the current page
  p_page_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (inc_wr && !load && !set_top && !inc_rd) |=> (ptr[AW-1:PW] == $past(ptr[AW-1:PW])));
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
  import sms_pkg::*;
#(
  parameter int AW          = 16,
  parameter int PAGE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [1:0]    cs_pins,
  input  logic          cs_en,
  input  logic          wr_busy,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          pw_load,
  output logic [AW-1:0] pw_addr,
  output logic [7:0]    pw_data,
  output logic          pw_commit,
  output logic          pw_cancel
);
  localparam int HI_W = AW - 9;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;

  sms_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  sms_state_e       state_q;
  sms_phase_e       phase_q;
  logic [2:0]       bitcnt_q;
  logic [7:0]       shreg_q;
  logic             rw_q, blk_q, ack_pend_q, staged_q;
  logic [HI_W-1:0]  addr_hi_q;
  logic [7:0]       rxbyte;
  logic             ctrl_ok, byte_fin, tx_load, quiet;
  logic             p_load, p_set_top, p_inc_rd, p_inc_wr;
  logic [AW-1:0]    ptr;

  assign quiet   = !start_ev && !stop_ev;
  assign rxbyte  = {shreg_q[6:0], sda_lvl};
  assign ctrl_ok = (rxbyte[7:4] == DEV_CODE) && (rxbyte[2:1] == cs_pins) && cs_en && !wr_busy;
  assign byte_fin = quiet && (state_q == ST_RX) && scl_rise && (bitcnt_q == 3'd7);
  assign tx_load  = quiet && scl_fall &&
                    (((state_q == ST_ACK) && (phase_q == PH_CTRL)) || (state_q == ST_TXNEXT));

  always_comb begin
    p_load    = byte_fin && (phase_q == PH_ALO);
    p_set_top = byte_fin && (phase_q == PH_CTRL) && ctrl_ok && rxbyte[0];
    p_inc_wr  = byte_fin && (phase_q == PH_DATA);
    p_inc_rd  = tx_load;
  end

  sms_addr_ptr #(.AW(AW), .PW(PAGE_W)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .load     (p_load),
    .load_val ({blk_q, addr_hi_q, rxbyte}),
    .set_top  (p_set_top),
    .top_val  (rxbyte[3]),
    .inc_rd   (p_inc_rd),
    .inc_wr   (p_inc_wr),
    .ptr      (ptr)
  );

  assign rd_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      phase_q    <= PH_CTRL;
      bitcnt_q   <= '0;
      shreg_q    <= '0;
      rw_q       <= 1'b0;
      blk_q      <= 1'b0;
      ack_pend_q <= 1'b0;
      staged_q   <= 1'b0;
      addr_hi_q  <= '0;
      sda_oe     <= 1'b0;
      pw_load    <= 1'b0;
      pw_addr    <= '0;
      pw_data    <= '0;
      pw_commit  <= 1'b0;
      pw_cancel  <= 1'b0;
    end else begin
      pw_load   <= 1'b0;
      pw_commit <= 1'b0;
      pw_cancel <= 1'b0;
      if (start_ev) begin
        state_q  <= ST_RX;
        phase_q  <= PH_CTRL;
        bitcnt_q <= '0;
        sda_oe   <= 1'b0;
        pw_cancel <= staged_q;
        staged_q <= 1'b0;
      end else if (stop_ev) begin
        state_q  <= ST_IDLE;
        phase_q  <= PH_CTRL;
        sda_oe   <= 1'b0;
        pw_commit <= staged_q;
        staged_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise) begin
              shreg_q  <= rxbyte;
              bitcnt_q <= bitcnt_q + 3'd1;
              if (bitcnt_q == 3'd7) begin
                state_q    <= ST_RXEND;
                ack_pend_q <= (phase_q != PH_CTRL) || ctrl_ok;
                unique case (phase_q)
                  PH_CTRL: begin
                    rw_q  <= rxbyte[0];
                    blk_q <= rxbyte[3];
                    if (!rxbyte[0]) phase_q <= PH_AHI;
                  end
                  PH_AHI: begin
                    addr_hi_q <= rxbyte[HI_W-1:0];
                    phase_q   <= PH_ALO;
                  end
                  PH_ALO: phase_q <= PH_DATA;
                  PH_DATA: begin
                    pw_load  <= 1'b1;
                    pw_addr  <= ptr;
                    pw_data  <= rxbyte;
                    staged_q <= 1'b1;
                  end
                  default: phase_q <= PH_CTRL;
                endcase
              end
            end
          end
          ST_RXEND: begin
            if (scl_fall) begin
              if (ack_pend_q) begin
                sda_oe  <= 1'b1;
                state_q <= ST_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt_q <= '0;
              if (phase_q == PH_CTRL && rw_q) begin
                shreg_q <= rd_data;
                sda_oe  <= ~rd_data[7];
                state_q <= ST_TX;
              end else begin
                sda_oe  <= 1'b0;
                state_q <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt_q == 3'd7) begin
                sda_oe  <= 1'b0;
                state_q <= ST_TXACK;
              end else begin
                shreg_q  <= {shreg_q[6:0], 1'b0};
                sda_oe   <= ~shreg_q[6];
                bitcnt_q <= bitcnt_q + 3'd1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) state_q <= sda_lvl ? ST_IDLE : ST_TXNEXT;
          end
          ST_TXNEXT: begin
            if (scl_fall) begin
              shreg_q  <= rd_data;
              sda_oe   <= ~rd_data[7];
              bitcnt_q <= '0;
              state_q  <= ST_TX;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R3: any Start restarts control-byte reception
  p_restart_r3: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> (state_q == ST_RX && bitcnt_q == 3'd0 && phase_q == PH_CTRL));

  // R6: a Stop always leaves SDA released and commit never overlaps a load
  p_stop_release_r6: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> !sda_oe);
  p_commit_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(pw_commit && (pw_load || pw_cancel)));

  // R7: a control byte seen while busy is never marked for acknowledge
  p_no_ack_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (byte_fin && phase_q == PH_CTRL && wr_busy) |=> !ack_pend_q);

  // R12: the block starts pulling SDA only while SCL is low
  p_drive_low_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_lvl);
endmodule

// File: tb/sim_serial_mem_slave.sv
`timescale 1ns/1ps
module sim_serial_mem_slave;
  localparam int AW = 16;
  localparam int Q  = 12;
  localparam int BUSY_CLKS = 900;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic m_scl = 1'b1, m_sda_low = 1'b0;
  logic sda_oe, wr_busy, pw_load, pw_commit, pw_cancel, sda_line;
  logic [1:0] cs_pins = 2'b10;
  logic cs_en = 1'b1;
  logic [AW-1:0] rd_addr, pw_addr;
  logic [7:0] rd_data, pw_data;

  assign sda_line = ~(m_sda_low | sda_oe);

  serial_mem_slave u0 (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .cs_pins(cs_pins), .cs_en(cs_en), .wr_busy(wr_busy),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .pw_load(pw_load), .pw_addr(pw_addr), .pw_data(pw_data),
    .pw_commit(pw_commit), .pw_cancel(pw_cancel)
  );

  // array and page-write unit model
  logic [7:0] mem [0:65535];
  logic [7:0] exp_mem [0:65535];
  logic [7:0] pbuf [0:63];
  logic [63:0] pval;
  logic [9:0] phi;
  int busy_cnt;
  assign wr_busy = (busy_cnt != 0);

  function automatic logic [7:0] init_pat(input int a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    rd_data <= mem[rd_addr];
    if (rst) begin
      pval <= '0; busy_cnt <= 0;
    end else begin
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (pw_load) begin
        pbuf[pw_addr[5:0]] <= pw_data;
        pval[pw_addr[5:0]] <= 1'b1;
        phi <= pw_addr[15:6];
      end
      if (pw_cancel) pval <= '0;
      if (pw_commit) begin
        for (int k = 0; k < 64; k++) if (pval[k]) mem[{phi, k[5:0]}] = pbuf[k];
        pval <= '0;
        busy_cnt <= BUSY_CLKS;
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_ptr = '0;
  logic done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] nxt_rd(input logic [15:0] a);
    return {a[15], a[14:0] + 15'd1};
  endfunction
  function automatic logic [15:0] nxt_wr(input logic [15:0] a);
    return {a[15:6], a[5:0] + 6'd1};
  endfunction
  function automatic logic [7:0] ctl(input logic blk, input logic [1:0] cs, input logic rw);
    return {4'b1010, blk, cs, rw};
  endfunction

  task automatic wq; repeat (Q) @(negedge clk); endtask
  task automatic m_start;
    m_sda_low = 1'b0; wq; m_scl = 1'b1; wq; m_sda_low = 1'b1; wq; m_scl = 1'b0; wq;
  endtask
  task automatic m_stop;
    m_sda_low = 1'b1; wq; m_scl = 1'b1; wq; m_sda_low = 1'b0; wq; wq;
  endtask
  task automatic m_bit(input logic b, output logic r);
    m_sda_low = ~b; wq; m_scl = 1'b1; wq; r = sda_line; wq; m_scl = 1'b0; wq;
  endtask
  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(d[i], r);
    m_bit(1'b1, r);
    ack = ~r;
  endtask
  task automatic recv_byte(output logic [7:0] d, input logic mack);
    logic r;
    d = '0;
    for (int i = 0; i < 8; i++) begin m_bit(1'b1, r); d = {d[6:0], r}; end
    m_bit(~mack, r);
    // R12: with a NACK, the line must stay high, so the slave is released
    if (!mack) chk(r == 1'b1, "R12 released in master ack slot", r, 1);
  endtask

  logic [7:0] wbuf [0:7];

  task automatic poll_done;
    logic ack;
    m_start; send_byte(ctl(1'b0, cs_pins, 1'b0), ack); m_stop;
    chk(!ack, "R7 no ack while write cycle runs", ack, 0);
    for (int i = 0; i < 20 && !ack; i++) begin
      m_start; send_byte(ctl(1'b0, cs_pins, 1'b0), ack); m_stop;
    end
    chk(ack, "R7 ack returns after write cycle", ack, 1);
  endtask

  task automatic set_addr(input logic blk, input logic [7:0] ah, input logic [7:0] al);
    logic ack;
    m_start;
    send_byte(ctl(blk, cs_pins, 1'b0), ack); chk(ack, "R1 write control ack", ack, 1);
    send_byte(ah, ack); chk(ack, "R4 high address ack", ack, 1);
    send_byte(al, ack); chk(ack, "R4 low address ack", ack, 1);
    exp_ptr = {blk, ah[6:0], al};
  endtask

  task automatic do_write(input logic blk, input logic [7:0] ah, input logic [7:0] al, input int n);
    logic ack;
    logic [15:0] a;
    set_addr(blk, ah, al);
    a = exp_ptr;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack); chk(ack, "R4 data ack", ack, 1);
      exp_mem[a] = wbuf[i];
      a = nxt_wr(a);
    end
    exp_ptr = a;
    m_stop;
    if (n > 0) poll_done;
  endtask

  // begins with a (repeated) Start and reads n bytes at the expected pointer
  task automatic do_read(input logic blk, input int n);
    logic ack;
    logic [7:0] d;
    logic [15:0] a;
    m_start;
    send_byte(ctl(blk, cs_pins, 1'b1), ack); chk(ack, "R1 read control ack", ack, 1);
    a = {blk, exp_ptr[14:0]};
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i < n - 1);
      chk(d == exp_mem[a], "R9/R11 read data", d, exp_mem[a]);
      a = nxt_rd(a);
    end
    exp_ptr = a;
    m_stop;
  endtask

  initial begin
    repeat (BUSY_CLKS * 200) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired (all requirements) act=%0d exp=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int rnd;
    for (int a = 0; a < 65536; a++) begin mem[a] = init_pat(a); exp_mem[a] = init_pat(a); end
    rnd = $urandom(32'd4711);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R13 reset state
    chk(sda_oe == 1'b0, "R13 SDA released after reset", sda_oe, 0);
    chk({pw_load, pw_commit, pw_cancel} == 3'b000, "R13 no pulses after reset",
        {pw_load, pw_commit, pw_cancel}, 0);

    // R1 wrong chip select and wrong code
    m_start; send_byte(ctl(1'b0, 2'b01, 1'b0), ack); m_stop;
    chk(!ack, "R1 chip-select mismatch not acked", ack, 0);
    m_start; send_byte(8'b1011_0100, ack); m_stop;
    chk(!ack, "R1 wrong device code not acked", ack, 0);
    // R2 enable strap low
    cs_en = 1'b0;
    m_start; send_byte(ctl(1'b0, cs_pins, 1'b1), ack); m_stop;
    chk(!ack, "R2 disabled device silent", ack, 0);
    cs_en = 1'b1;

    // R4/R11 byte write then current read; bit 7 of the high byte set
    wbuf[0] = 8'hC3;
    do_write(1'b1, 8'hA5, 8'h10, 1);
    chk(exp_ptr == 16'hA511, "R11 pointer after byte write", exp_ptr, 16'hA511);
    set_addr(1'b1, 8'h25, 8'h10); do_read(1'b1, 1);
    do_read(1'b1, 2); // R11 current-address read follows on

    // R5 page wrap
    for (int i = 0; i < 4; i++) wbuf[i] = 8'h90 + i[7:0];
    do_write(1'b0, 8'h12, 8'h3E, 4);
    set_addr(1'b0, 8'h12, 8'h00); do_read(1'b0, 2);
    set_addr(1'b0, 8'h12, 8'h3E); do_read(1'b0, 2);
    set_addr(1'b0, 8'h12, 8'h40); do_read(1'b0, 1);

    // R10 rollover in both halves, then R8 half bit from the read control byte
    set_addr(1'b0, 8'h7F, 8'hFF); do_read(1'b0, 3);
    set_addr(1'b1, 8'h7F, 8'hFF); do_read(1'b1, 3);
    chk(exp_ptr == 16'h8002, "R10 upper half wrap pointer", exp_ptr, 16'h8002);
    set_addr(1'b1, 8'h00, 8'h20); do_read(1'b0, 1);

    // R3 Start in the middle of the low address byte leaves the pointer alone
    set_addr(1'b0, 8'h05, 8'h06);
    m_stop;
    m_start; send_byte(ctl(1'b1, cs_pins, 1'b0), ack); send_byte(8'h33, ack);
    for (int i = 0; i < 3; i++) m_bit(1'b1, d[0]);
    do_read(1'b0, 1);
    chk(exp_ptr == 16'h0507, "R3 aborted address kept pointer", exp_ptr, 16'h0507);

    // R6 repeated Start after data cancels the write
    set_addr(1'b0, 8'h40, 8'h00);
    send_byte(8'hEE, ack); send_byte(8'hEF, ack);
    exp_ptr = 16'h4002;
    set_addr(1'b0, 8'h40, 8'h00); do_read(1'b0, 2);
    // address-only write followed by Stop: no write cycle, next control acked at once
    set_addr(1'b0, 8'h41, 8'h00); m_stop;
    m_start; send_byte(ctl(1'b0, cs_pins, 1'b1), ack);
    chk(ack, "R6 no write cycle after address-only write", ack, 1);
    recv_byte(d, 1'b0); m_stop;
    chk(d == exp_mem[16'h4100], "R6 data after address-only write", d, exp_mem[16'h4100]);
    exp_ptr = 16'h4101;

    // constrained random mix
    for (int t = 0; t < 12; t++) begin
      int kind, n;
      logic blk;
      logic [7:0] ah, al;
      kind = $urandom_range(2, 0);
      n = $urandom_range(4, 1);
      blk = 1'($urandom);
      ah = 8'($urandom);
      al = 8'($urandom);
      case (kind)
        0: begin
          for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
          do_write(blk, ah, al, n);
        end
        1: begin set_addr(blk, ah, al); do_read(blk, n); end
        default: do_read(blk, n);
      endcase
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule